// File: doc/BRIEF.md
# Burst-Synchronised Slave Data Clock Generator

This block sits on the remote end of a ping-pong line link that runs an 8 kHz frame. It has no free-running data clock. A one-cycle pulse from the burst demodulator restarts a sequence of exactly sixteen data clock periods, so any slip between the two ends is absorbed once per frame. The data clock comes from a parameterised divider of the system clock: a half period is `HALF_DIV` system clocks, and with 4.096 MHz and `HALF_DIV = 16` that gives 128 kHz. Along with the data clock the block produces two channel enables and a slower signaling clock. On the falling edges of the data clock it captures one or two channel bytes from a serial pin.

Captured bytes leave the block on a valid/ready stream. A byte is held with stable data until `m_ready_i` is seen high. Bytes arrive at a fixed rate set by the line, so there is no back-pressure towards the line. A newer byte that completes while an older one is still unaccepted overwrites it.

A tone request input hands frame timing to an internal frame timer, so the clocks keep running without received bursts. A received burst takes timing back. A low level on `dclk_allow_i` silences the data clock and suppresses capture.

Top module: `slave_burst_clkgen`

## Requirements
- R1: During and just after reset, `dclk_o`, `en1_o`, `en2_o`, `sclk_o` and `m_valid_o` are all low.
- R2: A start is a `burst_i` pulse, or a frame tick from the tone timer. In the cycle after a start, `en1_o` and `dclk_o` are high. `dclk_o` has a period of 2*HALF_DIV cycles and is high for the first HALF_DIV cycles of each period.
- R3: After a start the data clock runs exactly 16 periods (32*HALF_DIV cycles). It then stays low, with `en1_o`, `en2_o` and `sclk_o` also low, until the next start.
- R4: `en1_o` is high during data clock periods 0 to 7. In two-channel mode (`two_chan_i` = 1), `en2_o` is high during periods 8 to 15. In single-channel mode, `en2_o` stays low.
- R5: In two-channel mode, `sclk_o` is high during periods 0 to 3 and 8 to 11 and low otherwise, so it makes two cycles that rise together with `en1_o`. In single-channel mode, `sclk_o` equals `en1_o`.
- R6: `rx_i` is sampled on each falling edge of the data clock, MSB first. The byte from periods 0 to 7 is delivered with `m_chan_o` = 0. In two-channel mode, the byte from periods 8 to 15 is delivered with `m_chan_o` = 1. `m_valid_o` rises in the cycle after the eighth falling edge.
- R7: While `m_valid_o` is high and `m_ready_i` is low, `m_data_o` stays stable unless a newer byte completes, which replaces it. After a cycle with both high, `m_valid_o` falls.
- R8: A start that arrives while the sequence is running restarts it at period 0.
- R9: While `dclk_allow_i` is low, `dclk_o` stays low. A byte whose eight sample slots are not all taken with `dclk_allow_i` high is not delivered. The enables and `sclk_o` are not affected.
- R10: A rising edge on `tone_i` issues a start one cycle later, and then one start every 32*HALF_DIV cycles while `tone_i` stays high. When `tone_i` is low, no new start comes from the timer, though the frame already running completes.
- R11: A `burst_i` pulse while `tone_i` is high disarms the tone timer until `tone_i` is lowered and raised again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (2*HALF_DIV times the data clock rate) |
| rst_n | input | 1 | Active-low asynchronous reset |
| burst_i | input | 1 | One-cycle pulse: a burst from the far end was demodulated |
| two_chan_i | input | 1 | 1 selects two-channel framing, 0 single-channel |
| tone_i | input | 1 | Tone request: the internal frame timer drives the timing |
| dclk_allow_i | input | 1 | Low forces the data clock off and blocks capture |
| rx_i | input | 1 | Serial channel data in |
| m_ready_i | input | 1 | Byte stream ready |
| dclk_o | output | 1 | Gated data clock |
| en1_o | output | 1 | Channel 1 frame enable |
| en2_o | output | 1 | Channel 2 frame enable |
| sclk_o | output | 1 | Signaling clock |
| m_valid_o | output | 1 | Byte stream valid |
| m_data_o | output | 8 | Captured byte |
| m_chan_o | output | 1 | Channel of the byte (0 or 1) |

## Verification
Every output is compared cycle by cycle against a frame position computed arithmetically, for these patterns:
- a single burst in each channel mode, which separates the enable and signaling clock shapes of the two modes;
- a second burst part-way through a frame, which separates a restart from an ignored pulse;
- a frame with the data clock disabled, which shows that capture is gated while the framing is not;
- a frame with ready held low, which shows byte holding and overwrite.

Tone runs span frame boundaries, to show that timer frames join with no gap. A tone run that is ended part-way through a frame, and another that is interrupted by a burst, separate a clean stop and a disarm from free running.

// File: rtl/slave_clk_pkg.sv
package slave_clk_pkg;
  localparam int FRAME_PERIODS = 16;
  localparam int BYTE_BITS     = 8;
  localparam int PER_W         = $clog2(FRAME_PERIODS);
  localparam int SLOT_W        = $clog2(BYTE_BITS);
endpackage

// File: rtl/slave_tone_timer.sv
module slave_tone_timer #(
  parameter int FRAME_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tone_i,
  input  logic burst_i,
  output logic tick_o
);
  localparam int CW = (FRAME_CYC > 1) ? $clog2(FRAME_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(FRAME_CYC - 1);

  logic          tone_q;
  logic          armed;
  logic [CW-1:0] cnt;
  logic          tone_rise;

  assign tone_rise = tone_i & ~tone_q;
  assign tick_o    = armed & tone_i & (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tone_q <= 1'b0;
      armed  <= 1'b0;
      cnt    <= '0;
    end else begin
      tone_q <= tone_i;
      if (burst_i || !tone_i)  armed <= 1'b0;
      else if (tone_rise)      armed <= 1'b1;
      if (tone_rise)           cnt <= '0;
      else if (armed)          cnt <= (cnt == CNT_LAST) ? '0 : cnt + 1'b1;
    end
  end

  a_r10_no_tick_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    !tone_i |=> !tick_o);
  a_r11_burst_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    burst_i |=> !tick_o);
endmodule

// File: rtl/slave_clk_seq.sv
module slave_clk_seq
  import slave_clk_pkg::*;
#(
  parameter int HALF_DIV = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             two_chan_i,
  input  logic             dclk_allow_i,
  output logic             dclk_o,
  output logic             en1_o,
  output logic             en2_o,
  output logic             sclk_o,
  output logic             fall_o,
  output logic [PER_W-1:0] period_o
);
  localparam int PH_W = $clog2(2 * HALF_DIV);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(2 * HALF_DIV - 1);
  localparam logic [PH_W-1:0]  PH_FALL  = PH_W'(HALF_DIV - 1);
  localparam logic [PH_W-1:0]  PH_HALF  = PH_W'(HALF_DIV);
  localparam logic [PER_W-1:0] PER_LAST = PER_W'(FRAME_PERIODS - 1);

  logic             running;
  logic [PH_W-1:0]  ph;
  logic [PER_W-1:0] per;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      ph      <= '0;
      per     <= '0;
    end else if (start_i) begin
      running <= 1'b1;
      ph      <= '0;
      per     <= '0;
    end else if (running) begin
      if (ph == PH_LAST) begin
        ph  <= '0;
        per <= per + 1'b1;
        if (per == PER_LAST) running <= 1'b0;
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end

  always_comb begin
    dclk_o   = running & (ph < PH_HALF) & dclk_allow_i;
    en1_o    = running & ~per[PER_W-1];
    en2_o    = running & per[PER_W-1] & two_chan_i;
    sclk_o   = two_chan_i ? (running & ~per[PER_W-2]) : en1_o;
    fall_o   = running & (ph == PH_FALL) & ~start_i;
    period_o = per;
  end

  a_r2_start_raises_en1: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> en1_o);
  a_r3_stops_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (running && per == PER_LAST && ph == PH_LAST && !start_i) |=> (!en1_o && !en2_o && !dclk_o));
  a_r4_enables_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    en2_o |-> !en1_o);
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && running) |=> (per == '0 && ph == '0));
endmodule

// File: rtl/slave_byte_cap.sv
module slave_byte_cap
  import slave_clk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fall_i,
  input  logic [PER_W-1:0]     period_i,
  input  logic                 two_chan_i,
  input  logic                 dclk_allow_i,
  input  logic                 rx_i,
  input  logic                 m_ready_i,
  output logic                 m_valid_o,
  output logic [BYTE_BITS-1:0] m_data_o,
  output logic                 m_chan_o
);
  logic [BYTE_BITS-2:0] sh;
  logic                 clean;
  logic                 ok_now;
  logic                 deliver;
  logic [SLOT_W-1:0]    slot;
  logic [BYTE_BITS-1:0] word;

  always_comb begin
    slot    = period_i[SLOT_W-1:0];
    ok_now  = ((slot == '0) ? 1'b1 : clean) & dclk_allow_i;
    word    = {sh, rx_i};
    deliver = fall_i & (slot == SLOT_W'(BYTE_BITS - 1)) & ok_now &
              (~period_i[PER_W-1] | two_chan_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh    <= '0;
      clean <= 1'b0;
    end else if (fall_i) begin
      sh    <= word[BYTE_BITS-2:0];
      clean <= ok_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid_o <= 1'b0;
      m_data_o  <= '0;
      m_chan_o  <= 1'b0;
    end else if (deliver) begin
      m_valid_o <= 1'b1;
      m_data_o  <= word;
      m_chan_o  <= period_i[PER_W-1];
    end else if (m_valid_o && m_ready_i) begin
      m_valid_o <= 1'b0;
    end
  end

  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid_o && !m_ready_i && !deliver) |=> (m_valid_o && $stable(m_data_o) && $stable(m_chan_o)));
  a_r7_drop_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid_o && m_ready_i && !deliver) |=> !m_valid_o);
  a_r9_no_byte_when_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_i && !dclk_allow_i) |=> !$rose(m_valid_o));
endmodule

// File: rtl/slave_burst_clkgen.sv
module slave_burst_clkgen
  import slave_clk_pkg::*;
#(
  parameter int HALF_DIV = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       burst_i,
  input  logic       two_chan_i,
  input  logic       tone_i,
  input  logic       dclk_allow_i,
  input  logic       rx_i,
  input  logic       m_ready_i,
  output logic       dclk_o,
  output logic       en1_o,
  output logic       en2_o,
  output logic       sclk_o,
  output logic       m_valid_o,
  output logic [7:0] m_data_o,
  output logic       m_chan_o
);
  localparam int FRAME_CYC = 2 * HALF_DIV * FRAME_PERIODS;

  logic             tone_tick;
  logic             start;
  logic             fall;
  logic [PER_W-1:0] period;

  assign start = burst_i | tone_tick;

  slave_tone_timer #(.FRAME_CYC(FRAME_CYC)) tone_i0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .tone_i  (tone_i),
    .burst_i (burst_i),
    .tick_o  (tone_tick)
  );

  slave_clk_seq #(.HALF_DIV(HALF_DIV)) seq_i0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start),
    .two_chan_i   (two_chan_i),
    .dclk_allow_i (dclk_allow_i),
    .dclk_o       (dclk_o),
    .en1_o        (en1_o),
    .en2_o        (en2_o),
    .sclk_o       (sclk_o),
    .fall_o       (fall),
    .period_o     (period)
  );

  slave_byte_cap cap_i0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .fall_i       (fall),
    .period_i     (period),
    .two_chan_i   (two_chan_i),
    .dclk_allow_i (dclk_allow_i),
    .rx_i         (rx_i),
    .m_ready_i    (m_ready_i),
    .m_valid_o    (m_valid_o),
    .m_data_o     (m_data_o),
    .m_chan_o     (m_chan_o)
  );

  a_r9_gated_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!dclk_allow_i && $past(!dclk_allow_i)) |-> !dclk_o);
endmodule

// File: tb/slave_burst_clkgen_tb.sv
`timescale 1ns/1ps
module slave_burst_clkgen_tb_top;
  localparam int H  = 2;
  localparam int FR = 32 * H;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic burst = 1'b0, two = 1'b1, tone = 1'b0, allow = 1'b1, rx = 1'b0, rdy = 1'b1;
  logic dclk, en1, en2, sclk, mv, mc;
  logic [7:0] md;

  int checks = 0;
  int errors = 0;
  int cur_t = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  slave_burst_clkgen #(.HALF_DIV(H)) dut_i (
    .clk(clk), .rst_n(rst_n), .burst_i(burst), .two_chan_i(two), .tone_i(tone),
    .dclk_allow_i(allow), .rx_i(rx), .m_ready_i(rdy), .dclk_o(dclk), .en1_o(en1),
    .en2_o(en2), .sclk_o(sclk), .m_valid_o(mv), .m_data_o(md), .m_chan_o(mc)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s t=%0d actual=%0d expected=%0d", req, cur_t, act, exp);
    end
  endtask

  task automatic send_burst();
    burst = 1'b1;
    @(negedge clk);
    burst = 1'b0;
  endtask

  task automatic tone_on();
    tone = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_idle(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      cur_t = i;
      chk(dclk == 1'b0, {tag, " R3 dclk"}, dclk, 0);
      chk(en1 == 1'b0 && en2 == 1'b0, {tag, " R3 enables"}, {en1, en2}, 0);
      chk(sclk == 1'b0, {tag, " R3 sclk"}, sclk, 0);
      chk(mv == 1'b0, {tag, " R7 valid"}, mv, 0);
      @(negedge clk);
    end
  endtask

  task automatic check_cycles(input int t0, input int n, input bit tw, input bit periodic,
                              input bit allow_exp, input bit ready_on,
                              input logic [7:0] b1, input logic [7:0] b2, input string tag);
    for (int i = 0; i < n; i++) begin
      int t, ft, per, ph;
      bit act, e_dclk, e_en1, e_en2, e_sclk, e_v, e_c;
      logic [7:0] e_d, cur_b;
      t = t0 + i;
      cur_t = t;
      ft = periodic ? (t % FR) : t;
      act = periodic || (t < FR);
      per = ft / (2 * H);
      ph = ft % (2 * H);
      e_dclk = act && (ph < H) && allow_exp;
      e_en1 = act && (per < 8);
      e_en2 = act && tw && (per >= 8);
      e_sclk = tw ? (act && ((per % 8) < 4)) : e_en1;
      if (ready_on) begin
        e_v = act && allow_exp && ((ft == 15 * H) || (tw && ft == 31 * H));
        e_c = (ft == 31 * H);
      end else begin
        e_v = act && allow_exp && (ft >= 15 * H);
        e_c = tw && (ft >= 31 * H);
      end
      e_d = e_c ? b2 : b1;
      chk(dclk == e_dclk, {tag, " R2 dclk"}, dclk, e_dclk);
      chk(en1 == e_en1, {tag, " R4 en1"}, en1, e_en1);
      chk(en2 == e_en2, {tag, " R4 en2"}, en2, e_en2);
      chk(sclk == e_sclk, {tag, " R5 sclk"}, sclk, e_sclk);
      chk(mv == e_v, {tag, " R6 valid"}, mv, e_v);
      if (e_v) begin
        chk(md == e_d, {tag, " R6 data"}, md, e_d);
        chk(mc == e_c, {tag, " R6 chan"}, mc, e_c);
      end
      cur_b = (per < 8) ? b1 : b2;
      rx = cur_b[7 - (per % 8)];
      @(negedge clk);
    end
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(dclk == 0 && en1 == 0 && en2 == 0 && sclk == 0 && mv == 0, "R1 in reset",
        {dclk, en1, en2, sclk, mv}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dclk == 0 && en1 == 0 && en2 == 0 && sclk == 0 && mv == 0, "R1 after reset",
        {dclk, en1, en2, sclk, mv}, 0);

    two = 1'b1;
    send_burst();
    check_cycles(0, FR, 1'b1, 1'b0, 1'b1, 1'b1, 8'hA5, 8'h3C, "R3 two-chan");
    check_idle(10, "R3");

    two = 1'b0;
    send_burst();
    check_cycles(0, FR, 1'b0, 1'b0, 1'b1, 1'b1, 8'h5A, 8'hFF, "R4 single-chan");
    check_idle(10, "R5");

    two = 1'b1;
    send_burst();
    check_cycles(0, 22, 1'b1, 1'b0, 1'b1, 1'b1, 8'h11, 8'h22, "R8 first");
    send_burst();
    check_cycles(0, FR, 1'b1, 1'b0, 1'b1, 1'b1, 8'h96, 8'h69, "R8 restarted");
    check_idle(10, "R8");

    allow = 1'b0;
    send_burst();
    check_cycles(0, FR, 1'b1, 1'b0, 1'b0, 1'b1, 8'hF0, 8'h0F, "R9 gated");
    allow = 1'b1;
    check_idle(10, "R9");

    rdy = 1'b0;
    send_burst();
    check_cycles(0, FR, 1'b1, 1'b0, 1'b1, 1'b0, 8'hC3, 8'h81, "R7 held");
    chk(mv == 1'b1 && md == 8'h81 && mc == 1'b1, "R7 replaced byte held", md, 8'h81);
    rdy = 1'b1;
    @(negedge clk);
    chk(mv == 1'b0, "R7 valid drops after accept", mv, 0);
    check_idle(5, "R7");

    tone_on();
    check_cycles(0, 96, 1'b1, 1'b1, 1'b1, 1'b1, 8'h7E, 8'hB4, "R10 tone");
    tone = 1'b0;
    check_cycles(96, 32, 1'b1, 1'b1, 1'b1, 1'b1, 8'h7E, 8'hB4, "R10 tone tail");
    check_idle(FR + 8, "R10");

    tone_on();
    check_cycles(0, 40, 1'b1, 1'b1, 1'b1, 1'b1, 8'h33, 8'hCC, "R10 tone again");
    send_burst();
    check_cycles(0, FR, 1'b1, 1'b0, 1'b1, 1'b1, 8'hE7, 8'h18, "R11 burst frame");
    check_idle(FR + 16, "R11");
    tone = 1'b0;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule